// File: doc/BRIEF.md
# Flash bus mode and reset sequencer

This block is the pin-facing control of a parallel NOR-style flash device. From the four active-low control pins (reset, chip enable, output enable, write enable) it works out the current bus mode: read, output disable, standby, reset, write, or the illegal case where output enable and write enable are both low. It drives the enable of the data output buffers and flags when read data is valid and when a write may be taken. It also tells the power logic whether the part is active, in standby or held in reset.

Reset is accepted only after the reset pin has stayed low for a minimum number of cycles. An accepted reset reinitialises the command interface to read-array mode, loads the status register with 0x80 and locks every lockable block. If a program or erase is busy when reset is accepted, the operation is aborted. A timed shutdown phase follows, and its end is the reference point for the read and write wake-up delays. The program/erase engine is reduced to a busy input and an abort request output.

Top module: `flash_busctl`

## Requirements
- R1: With `rp_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1, the block is in read mode, `dq_oe` is 1, and `rd_valid` is 1 once the read wake-up delay has elapsed.
- R2: With `ce_n`=0 and `oe_n`=1, or with `ce_n`=1 at any `oe_n` level, `dq_oe` is 0. `ce_n`=1 with `busy`=0 reports `pwr_state`=1 (standby). The `pwr_state` encoding is 0 active, 1 standby, 2 reset.
- R3: `rp_n`=0 forces `dq_oe` to 0 in the same cycle, whatever the other pins are. An accepted reset reports `pwr_state`=2.
- R4: A low pulse on `rp_n` that lasts fewer than T_PLPH consecutive sampled cycles is ignored. Lock bits, status and the wake-up timers are left untouched.
- R5: `rp_n` low for T_PLPH sampled cycles with `busy`=0 enters reset. When `rp_n` is released, `rd_valid` stays 0 for T_PHQV cycles and `wr_ready` stays 0 for T_PHWL cycles, both counted from the clock edge at which the rise is sampled.
- R6: While reset or shutdown is in force, `read_array` becomes 1, `status` becomes 0x80 and every bit of `lock` becomes 1. After that, `status[7]` reads as the inverse of `busy` and `status[6:0]` gathers `stat_set`.
- R7: While `busy`=1 and no reset is in force, `pwr_state` is 0 (active), even with `ce_n`=1.
- R8: A reset accepted while `busy`=1 raises `abort_req` for exactly T_PLRH cycles and sets `aborted`.
- R9: At the end of shutdown, the block returns to normal operation if `rp_n` is high and enters reset (`pwr_state`=2) if `rp_n` is still low. In both cases the read and write wake-up delays count from the end of shutdown.
- R10: A write is accepted on the first cycle of write mode (`rp_n`=1, `ce_n`=0, `oe_n`=1, `we_n`=0) in which `wr_ready` is 1. On the next cycle `wr_stb` pulses for one cycle with `wr_data` holding the sampled `din`, and `aborted` is cleared.
- R11: `ce_n`=0 with both `oe_n` and `we_n` low keeps `dq_oe` at 0 and takes no write. A write mode entered before `wr_ready` rises is not taken, even if it is held after `wr_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rp_n | input | 1 | Active-low reset pin |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| din | input | DW | Data bus input sampled on write |
| busy | input | 1 | Program/erase engine busy |
| stat_set | input | 7 | Status bits to set in status[6:0] |
| unlock | input | NBLK | Per-block lock clear pulses |
| cmd_leave | input | 1 | Command decoder leaves read-array mode |
| dq_oe | output | 1 | Data output buffer enable |
| rd_valid | output | 1 | Read data valid |
| wr_ready | output | 1 | Write may be accepted |
| wr_stb | output | 1 | One-cycle pulse for an accepted write |
| wr_data | output | DW | Data captured by the accepted write |
| pwr_state | output | 2 | 0 active, 1 standby, 2 reset |
| abort_req | output | 1 | Shutdown request to program/erase engine |
| aborted | output | 1 | Aborted location or block is invalid |
| read_array | output | 1 | Command interface in read-array mode |
| status | output | 8 | Status register |
| lock | output | NBLK | Block lock bits |

## Verification
The bench builds the block with T_PLPH=3, T_PHQV=4, T_PHWL=6, T_PLRH=5 and four lockable blocks. Because the read and write wake-up delays differ, there is a window in which reads are valid and writes are still refused, and a write entered in that window can be shown to be dropped. A five-cycle shutdown lets the bench release reset partway through it. The wake-up delays can then be told apart depending on whether they run from the pin's rise or from the end of shutdown. The same holds for the exit into reset and a later release. A three-cycle acceptance threshold leaves room for a two-cycle pulse that must be ignored.

// File: rtl/flash_busctl_pkg.sv
package flash_busctl_pkg;

    typedef enum logic [2:0] {
        BM_READ,
        BM_ODIS,
        BM_STBY,
        BM_RESET,
        BM_WRITE,
        BM_ILLEGAL
    } bus_mode_e;

    typedef enum logic [1:0] {
        PW_ACTIVE  = 2'd0,
        PW_STANDBY = 2'd1,
        PW_RESET   = 2'd2
    } pwr_e;

    typedef enum logic [1:0] {
        SQ_NORMAL,
        SQ_PEND,
        SQ_RESET,
        SQ_SHUT
    } seq_e;

    localparam logic [7:0] STATUS_INIT = 8'h80;

    // Pin levels to bus mode; reset dominates, then deselect.
    function automatic bus_mode_e decode_mode(input logic rp_n, input logic ce_n,
                                              input logic oe_n, input logic we_n);
        bus_mode_e m;
        if (!rp_n)              m = BM_RESET;
        else if (ce_n)          m = BM_STBY;
        else if (!oe_n && we_n) m = BM_READ;
        else if (oe_n && we_n)  m = BM_ODIS;
        else if (oe_n)          m = BM_WRITE;
        else                    m = BM_ILLEGAL;
        return m;
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
    import flash_busctl_pkg::*;
(
    input  logic      rp_n,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    output bus_mode_e mode
);
    assign mode = decode_mode(rp_n, ce_n, oe_n, we_n);
endmodule

// File: rtl/flash_wake_timer.sv
module flash_wake_timer #(
    parameter int T = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int TW = $clog2(T + 1);
    localparam logic [TW-1:0] T_VAL = TW'(T);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= T_VAL;
        else if (load)          cnt_q <= T_VAL;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq
    import flash_busctl_pkg::*;
#(
    parameter int T_PLPH = 3,
    parameter int T_PLRH = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic rp_n,
    input  logic busy,
    output seq_e state,
    output logic wake_load,
    output logic abort_set
);
    localparam int LW = (T_PLPH > 2) ? $clog2(T_PLPH) : 1;
    localparam int SW = (T_PLRH > 2) ? $clog2(T_PLRH) : 1;
    localparam logic [LW-1:0] LOW_LAST = LW'(T_PLPH - 1);
    localparam logic [SW-1:0] SD_LAST  = SW'(T_PLRH - 1);
    localparam bit QUICK = (T_PLPH <= 1);

    seq_e          st_q, st_d;
    logic [LW-1:0] low_q, low_d;
    logic [SW-1:0] sd_q, sd_d;
    logic          flag_q, flag_d;   // reset entered from shutdown: timers already run
    logic          accept;

    always_comb begin
        st_d      = st_q;
        low_d     = low_q;
        sd_d      = sd_q;
        flag_d    = flag_q;
        accept    = 1'b0;
        wake_load = 1'b0;
        case (st_q)
            SQ_NORMAL: begin
                if (!rp_n) begin
                    if (QUICK) accept = 1'b1;
                    else begin
                        st_d  = SQ_PEND;
                        low_d = LW'(1);
                    end
                end
            end
            SQ_PEND: begin
                if (rp_n)                   st_d = SQ_NORMAL;
                else if (low_q == LOW_LAST) accept = 1'b1;
                else                        low_d = low_q + 1'b1;
            end
            SQ_RESET: begin
                if (rp_n) begin
                    st_d      = SQ_NORMAL;
                    wake_load = !flag_q;
                end
            end
            SQ_SHUT: begin
                if (sd_q == SD_LAST) begin
                    wake_load = 1'b1;
                    if (rp_n) st_d = SQ_NORMAL;
                    else begin
                        st_d   = SQ_RESET;
                        flag_d = 1'b1;
                    end
                end else begin
                    sd_d = sd_q + 1'b1;
                end
            end
            default: st_d = SQ_RESET;
        endcase
        if (accept) begin
            sd_d   = '0;
            flag_d = 1'b0;
            st_d   = busy ? SQ_SHUT : SQ_RESET;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_RESET;
            low_q  <= '0;
            sd_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            low_q  <= low_d;
            sd_q   <= sd_d;
            flag_q <= flag_d;
        end
    end

    assign state     = st_q;
    assign abort_set = accept && busy;
endmodule

// File: rtl/flash_busctl.sv
module flash_busctl
    import flash_busctl_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NBLK   = 4,
    parameter int T_PLPH = 3,
    parameter int T_PHQV = 4,
    parameter int T_PHWL = 6,
    parameter int T_PLRH = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rp_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic [DW-1:0]   din,
    input  logic            busy,
    input  logic [6:0]      stat_set,
    input  logic [NBLK-1:0] unlock,
    input  logic            cmd_leave,
    output logic            dq_oe,
    output logic            rd_valid,
    output logic            wr_ready,
    output logic            wr_stb,
    output logic [DW-1:0]   wr_data,
    output logic [1:0]      pwr_state,
    output logic            abort_req,
    output logic            aborted,
    output logic            read_array,
    output logic [7:0]      status,
    output logic [NBLK-1:0] lock
);
    bus_mode_e mode;
    seq_e      state;
    pwr_e      pwr;
    logic      wake_load, abort_set, rd_done, wr_done;
    logic      in_reset, wr_take;

    logic            wr_seen_q, wr_stb_q, aborted_q, arr_q;
    logic [DW-1:0]   wr_data_q;
    logic [7:0]      stat_q;
    logic [NBLK-1:0] lock_q;

    flash_bus_decode u_dec (
        .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .mode(mode)
    );

    flash_rst_seq #(.T_PLPH(T_PLPH), .T_PLRH(T_PLRH)) u_seq (
        .clk(clk), .rst(rst), .rp_n(rp_n), .busy(busy),
        .state(state), .wake_load(wake_load), .abort_set(abort_set)
    );

    flash_wake_timer #(.T(T_PHQV)) u_rd_tmr (
        .clk(clk), .rst(rst), .load(wake_load), .done(rd_done)
    );

    flash_wake_timer #(.T(T_PHWL)) u_wr_tmr (
        .clk(clk), .rst(rst), .load(wake_load), .done(wr_done)
    );

    assign in_reset = (state == SQ_RESET) || (state == SQ_SHUT);
    assign dq_oe    = (state == SQ_NORMAL) && (mode == BM_READ);
    assign rd_valid = dq_oe && rd_done;
    assign wr_ready = (state == SQ_NORMAL) && rp_n && wr_done;
    assign wr_take  = wr_ready && (mode == BM_WRITE) && !wr_seen_q;

    always_comb begin
        if (state == SQ_RESET)      pwr = PW_RESET;
        else if (state == SQ_SHUT)  pwr = PW_ACTIVE;
        else if (busy)              pwr = PW_ACTIVE;
        else if (ce_n)              pwr = PW_STANDBY;
        else                        pwr = PW_ACTIVE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen_q <= 1'b0;
            wr_stb_q  <= 1'b0;
            wr_data_q <= '0;
            aborted_q <= 1'b0;
            stat_q    <= STATUS_INIT;
            lock_q    <= '1;
            arr_q     <= 1'b1;
        end else begin
            wr_seen_q <= (mode == BM_WRITE);
            wr_stb_q  <= wr_take;
            if (wr_take) wr_data_q <= din;
            if (abort_set)    aborted_q <= 1'b1;
            else if (wr_take) aborted_q <= 1'b0;
            if (in_reset) begin
                stat_q <= STATUS_INIT;
                lock_q <= '1;
                arr_q  <= 1'b1;
            end else begin
                stat_q <= {~busy, stat_q[6:0] | stat_set};
                lock_q <= lock_q & ~unlock;
                if (cmd_leave) arr_q <= 1'b0;
            end
        end
    end

    assign wr_stb     = wr_stb_q;
    assign wr_data    = wr_data_q;
    assign pwr_state  = pwr;
    assign abort_req  = (state == SQ_SHUT);
    assign aborted    = aborted_q;
    assign read_array = arr_q;
    assign status     = stat_q;
    assign lock       = lock_q;
endmodule

// File: rtl/flash_busctl_chk.sv
module flash_busctl_chk #(
    parameter int NBLK = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            rp_n,
    input logic            ce_n,
    input logic            oe_n,
    input logic            we_n,
    input logic            busy,
    input logic            dq_oe,
    input logic            rd_valid,
    input logic            wr_ready,
    input logic            wr_stb,
    input logic [1:0]      pwr_state,
    input logic            abort_req,
    input logic            aborted,
    input logic            read_array,
    input logic [7:0]      status,
    input logic [NBLK-1:0] lock
);
    AST_STBY_HIZ: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !dq_oe); // R2

    AST_RST_HIZ: assert property (@(posedge clk) disable iff (rst)
        !rp_n |-> !dq_oe); // R3

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd2) |=> (!rd_valid && !wr_ready)); // R5

    AST_REINIT: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd2 && $past(pwr_state == 2'd2))
        |-> (status == 8'h80 && (&lock) && read_array)); // R6

    AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (busy && pwr_state != 2'd2) |-> (pwr_state == 2'd0)); // R7

    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(abort_req) |-> aborted); // R8

    AST_WR_FROM_PINS: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(rp_n && !ce_n && oe_n && !we_n)); // R10

    AST_ILLEGAL_HIZ: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !we_n) |-> !dq_oe); // R11
endmodule

bind flash_busctl flash_busctl_chk #(.NBLK(NBLK)) u_chk (
    .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .dq_oe(dq_oe), .rd_valid(rd_valid), .wr_ready(wr_ready),
    .wr_stb(wr_stb), .pwr_state(pwr_state), .abort_req(abort_req),
    .aborted(aborted), .read_array(read_array), .status(status), .lock(lock)
);

// File: tb/flash_busctl_tb.sv
module flash_busctl_tb;
    localparam int DW = 8;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic          busy = 1'b0;
    logic [6:0]    stat_set = '0;
    logic [NB-1:0] unlock = '0;
    logic          cmd_leave = 1'b0;
    logic          dq_oe, rd_valid, wr_ready, wr_stb, abort_req, aborted, read_array;
    logic [DW-1:0] wr_data;
    logic [1:0]    pwr_state;
    logic [7:0]    status;
    logic [NB-1:0] lock;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_busctl #(.DW(DW), .NBLK(NB), .T_PLPH(3), .T_PHQV(4), .T_PHWL(6), .T_PLRH(5)) u_dut (
        .clk(clk), .rst(rst), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .din(din), .busy(busy), .stat_set(stat_set), .unlock(unlock), .cmd_leave(cmd_leave),
        .dq_oe(dq_oe), .rd_valid(rd_valid), .wr_ready(wr_ready), .wr_stb(wr_stb),
        .wr_data(wr_data), .pwr_state(pwr_state), .abort_req(abort_req), .aborted(aborted),
        .read_array(read_array), .status(status), .lock(lock)
    );

    // {busy, rp_n, ce_n, oe_n, we_n, dq_oe, pwr[1:0], req[3:0]}
    localparam logic [11:0] VEC [10] = '{
        12'b0_1001_1_00_0001,  // R1 read
        12'b0_1011_0_00_0010,  // R2 output disable
        12'b0_1101_0_01_0010,  // R2 standby, oe low
        12'b0_1110_0_01_0010,  // R2 standby, we low
        12'b0_1000_0_00_1011,  // R11 illegal oe+we low
        12'b0_1010_0_00_1010,  // R10 write mode, no drive
        12'b0_0001_0_00_0011,  // R3 reset pin low, read pins
        12'b0_0101_0_01_0011,  // R3 reset pin low, deselected
        12'b1_1111_0_00_0111,  // R7 busy while deselected
        12'b1_1101_0_00_0111   // R7 busy, deselected, oe low
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pins(input logic r, input logic c, input logic o, input logic w);
        rp_n = r; ce_n = c; oe_n = o; we_n = w;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(2);
        // reset state (R6, R3)
        check("R3 pwr in reset", 32'(pwr_state), 32'd2);
        check("R3 dq_oe in reset", 32'(dq_oe), 32'd0);
        check("R6 status init", 32'(status), 32'h80);
        check("R6 locks init", 32'(lock), 32'hF);
        check("R6 read array init", 32'(read_array), 32'd1);
        check("R5 wr_ready in reset", 32'(wr_ready), 32'd0);
        rst = 1'b0;
        step(8);

        // vector table walk, comb outputs only
        for (int i = 0; i < 10; i++) begin
            {busy, rp_n, ce_n, oe_n, we_n} = VEC[i][11:7];
            #1;
            check($sformatf("R%0d dq_oe row %0d", VEC[i][3:0], i), 32'(dq_oe), 32'(VEC[i][6]));
            check($sformatf("R%0d pwr row %0d", VEC[i][3:0], i), 32'(pwr_state), 32'(VEC[i][5:4]));
            check($sformatf("R%0d rd_valid row %0d", VEC[i][3:0], i), 32'(rd_valid), 32'(VEC[i][6]));
        end
        busy = 1'b0;
        pins(1, 1, 1, 1);
        step(1);

        // R4: short reset pulse ignored
        unlock = 4'b0001;
        step(1);
        unlock = '0;
        check("R6 unlock block 0", 32'(lock), 32'hE);
        pins(0, 1, 1, 1);
        step(2);
        pins(1, 1, 1, 1);
        step(1);
        check("R4 locks kept", 32'(lock), 32'hE);
        check("R4 pwr standby", 32'(pwr_state), 32'd1);
        pins(1, 0, 0, 1);
        check("R4 rd_valid kept", 32'(rd_valid), 32'd1);
        check("R4 wr_ready kept", 32'(wr_ready), 32'd1);
        pins(1, 1, 1, 1);

        // R6/R5: valid reset reinitialises, wake-up delays
        cmd_leave = 1'b1; stat_set = 7'h01;
        step(1);
        cmd_leave = 1'b0; stat_set = '0;
        check("R6 leave array", 32'(read_array), 32'd0);
        check("R6 status set", 32'(status), 32'h81);
        pins(0, 1, 1, 1);
        step(2);
        check("R4 not yet accepted", 32'(pwr_state), 32'd1);
        step(1);
        check("R3 reset accepted", 32'(pwr_state), 32'd2);
        step(1);
        check("R6 status reinit", 32'(status), 32'h80);
        check("R6 locks reinit", 32'(lock), 32'hF);
        check("R6 read array reinit", 32'(read_array), 32'd1);
        pins(1, 0, 0, 1);
        step(4);
        check("R1 dq_oe on read", 32'(dq_oe), 32'd1);
        check("R5 rd_valid before delay", 32'(rd_valid), 32'd0);
        step(1);
        check("R5 rd_valid after delay", 32'(rd_valid), 32'd1);
        pins(1, 0, 1, 0);
        step(1);
        check("R5 wr_ready before delay", 32'(wr_ready), 32'd0);
        step(1);
        check("R5 wr_ready after delay", 32'(wr_ready), 32'd1);
        check("R11 early write dropped", 32'(wr_stb), 32'd0);
        pins(1, 0, 1, 1);
        step(1);

        // R11 illegal, then R10 write
        din = 8'h3C;
        pins(1, 0, 0, 0);
        check("R11 illegal hi-z", 32'(dq_oe), 32'd0);
        step(1);
        check("R11 illegal no write", 32'(wr_stb), 32'd0);
        din = 8'hA5;
        pins(1, 0, 1, 0);
        step(1);
        check("R10 write strobe", 32'(wr_stb), 32'd1);
        check("R10 write data", 32'(wr_data), 32'hA5);
        step(1);
        check("R10 single strobe", 32'(wr_stb), 32'd0);
        pins(1, 1, 1, 1);
        step(1);

        // R8/R9: abort, reset released during shutdown
        busy = 1'b1;
        step(1);
        check("R6 status busy bit", 32'(status[7]), 32'd0);
        pins(0, 1, 1, 1);
        step(3);
        check("R8 abort_req", 32'(abort_req), 32'd1);
        check("R8 aborted flag", 32'(aborted), 32'd1);
        check("R7 shutdown active", 32'(pwr_state), 32'd0);
        busy = 1'b0;
        step(2);
        pins(1, 1, 1, 1);
        step(2);
        check("R8 abort_req last cycle", 32'(abort_req), 32'd1);
        step(1);
        check("R8 abort_req ended", 32'(abort_req), 32'd0);
        check("R9 normal after shutdown", 32'(pwr_state), 32'd1);
        check("R6 status after abort", 32'(status), 32'h80);
        pins(1, 0, 0, 1);
        step(3);
        check("R9 rd_valid before delay", 32'(rd_valid), 32'd0);
        step(1);
        check("R9 rd_valid from shutdown end", 32'(rd_valid), 32'd1);
        check("R8 aborted held", 32'(aborted), 32'd1);
        pins(1, 0, 1, 1);
        step(1);
        check("R9 wr_ready before delay", 32'(wr_ready), 32'd0);
        step(1);
        check("R9 wr_ready from shutdown end", 32'(wr_ready), 32'd1);
        din = 8'h5A;
        pins(1, 0, 1, 0);
        step(1);
        check("R10 write after abort", 32'(wr_data), 32'h5A);
        check("R10 aborted cleared", 32'(aborted), 32'd0);
        pins(1, 1, 1, 1);
        step(1);

        // R9: reset still low at end of shutdown
        busy = 1'b1;
        pins(0, 1, 1, 1);
        step(3);
        check("R8 second abort", 32'(abort_req), 32'd1);
        busy = 1'b0;
        step(5);
        check("R9 enters reset", 32'(pwr_state), 32'd2);
        check("R9 abort_req ended", 32'(abort_req), 32'd0);
        step(2);
        pins(1, 0, 0, 1);
        step(1);
        check("R9 rd_valid before delay", 32'(rd_valid), 32'd0);
        step(1);
        check("R9 rd_valid counted from shutdown", 32'(rd_valid), 32'd1);
        step(1);
        check("R9 wr_ready before delay", 32'(wr_ready), 32'd0);
        step(1);
        check("R9 wr_ready counted from shutdown", 32'(wr_ready), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule